// File: doc/BRIEF.md
# Single-Bank SDRAM Command Sequencer

This block turns single user reads and writes into command-level traffic for a DDR3-style memory. After reset it runs a fixed power-up sequence: a settling wait, a precharge of all banks, two refreshes in a row, and a load of mode register 0. It then waits in idle for a request. Each request opens a row with ACTIVATE and performs one READ or one WRITE. Every request after the first begins with a new precharge-all and one refresh.

Every command lasts one clock. A programmable number of NOP cycles follows each command, and a single down-counter times all of these gaps. All traffic goes to bank 0. The user port has a valid/ready handshake. Read data comes back with a one-cycle valid flag. The PHY layer, strobe timing, calibration and bursts longer than one access are left to other blocks.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises until the T_INIT-th rising clock edge, `mem_cmd` is NOP and `req_ready` is low. `mem_cmd` is {CS#,RAS#,CAS#,WE#}, and NOP is 4'b0111.
- R2: Power-up order is fixed. PRECHARGE-ALL comes first (4'b0010, `mem_addr` = 13'h0400, so only bit 10 is set), followed by T_RP NOPs. Next comes REFRESH (4'b0001) with T_RFC NOPs, then a second REFRESH with T_RFC NOPs. Last comes MODE-REGISTER-SET (4'b0000) with `mem_addr` = MR0_VAL, followed by T_MRD NOPs. Idle starts after that.
- R3: `mem_ba` is zero in every cycle.
- R4: `req_ready` is high exactly in idle cycles, and idle cycles carry NOP with `mem_addr` zero. A request is taken when `req_valid` and `req_ready` are both high. A `req_valid` raised while `req_ready` is low and dropped before idle has no effect.
- R5: The first request after power-up issues ACTIVATE (4'b0011, `mem_addr` = row) in the cycle right after acceptance, with no precharge before it.
- R6: Every later request first issues PRECHARGE-ALL (addr 13'h0400) with T_RP NOPs, then REFRESH with T_RFC NOPs, and only then ACTIVATE. An ACTIVATE never finds a row still open.
- R7: A write issues ACTIVATE, T_RCD NOPs, then WRITE (4'b0100) with `mem_addr` = column zero-extended (bit 10 low). `mem_dq_oe` is high and `mem_dq_out` = write data in that cycle only. T_WR NOPs follow, then idle.
- R8: A read issues ACTIVATE, T_RCD NOPs, READ (4'b0101, column, bit 10 low), then T_CL NOPs. `mem_dq_in` is sampled in the last of those NOP cycles. `rd_valid` is high for exactly the next cycle, carrying that sample on `rd_data`, and idle follows.
- R9: Each non-NOP command lasts one cycle and is followed by at least one NOP.
- R10: A read returns the data most recently written to the same row and column, including the all-ones row and column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | One-cycle read data flag |
| mem_cmd | output | 4 | {CS#,RAS#,CAS#,WE#} command code |
| mem_ba | output | BA_W | Bank select, held at 0 |
| mem_addr | output | 13 | Memory address bus |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
Two events can fall in the same cycle: the first idle cycle after an operation finishes, and the acceptance of a request that has been held pending during that operation. The bench provokes this by raising `req_valid` for the next operation while the previous one is still running. It also raises and drops a stray request during a busy window. A reference model in the bench builds the expected per-cycle command, address, ready and read-valid trace from the timing parameters and compares it on every clock. A behavioural bank-0 memory flags an ACTIVATE that finds a row open, and an access that finds no row open. The exact cycle at which the next sequence starts shows whether the held request was taken once, at the right edge, and whether the stray one was ignored.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } mem_cmd_e;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_INIT_PRE,
    ST_INIT_REF1,
    ST_INIT_REF2,
    ST_INIT_MRS,
    ST_IDLE,
    ST_PRE,
    ST_REF,
    ST_ACT,
    ST_WRITE,
    ST_READ,
    ST_RD_DONE
  } seq_state_e;

  localparam int AUTO_PRE_BIT = 10;
  localparam int MEM_ADDR_W   = 13;

  // Largest of the gap counts, used to size the single wait counter.
  function automatic int max_gap(input int a, input int b, input int c,
                                 input int d, input int e, input int f,
                                 input int g);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    if (f > m) m = f;
    if (g > m) m = g;
    return m;
  endfunction

  // Address pattern that selects all banks on a precharge.
  function automatic logic [MEM_ADDR_W-1:0] all_banks_addr();
    logic [MEM_ADDR_W-1:0] a;
    a = '0;
    a[AUTO_PRE_BIT] = 1'b1;
    return a;
  endfunction

endpackage

// File: rtl/seq_wait_ctr.sv
module seq_wait_ctr #(
  parameter int CNT_W     = 4,
  parameter int RESET_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= CNT_W'(RESET_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/seq_cmd_encode.sv
module seq_cmd_encode
  import sdram_seq_pkg::*;
#(
  parameter int                    ROW_W   = 13,
  parameter int                    COL_W   = 10,
  parameter logic [MEM_ADDR_W-1:0] MR0_VAL = 13'h0520
) (
  input  seq_state_e              state,
  input  logic [ROW_W-1:0]        row,
  input  logic [COL_W-1:0]        col,
  output logic [3:0]              cmd,
  output logic [MEM_ADDR_W-1:0]   addr
);

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    case (state)
      ST_INIT_PRE, ST_PRE: begin
        cmd  = CMD_PRE;
        addr = all_banks_addr();
      end
      ST_INIT_REF1, ST_INIT_REF2, ST_REF: cmd = CMD_REF;
      ST_INIT_MRS: begin
        cmd  = CMD_MRS;
        addr = MR0_VAL;
      end
      ST_ACT: begin
        cmd  = CMD_ACT;
        addr = MEM_ADDR_W'(row);
      end
      ST_WRITE: begin
        cmd  = CMD_WR;
        addr = MEM_ADDR_W'(col);
      end
      ST_READ: begin
        cmd  = CMD_RD;
        addr = MEM_ADDR_W'(col);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int          ROW_W   = 13,
  parameter int          COL_W   = 10,
  parameter int          DATA_W  = 16,
  parameter int          BA_W    = 3,
  parameter int          T_INIT  = 10,
  parameter int          T_RP    = 3,
  parameter int          T_RFC   = 6,
  parameter int          T_MRD   = 4,
  parameter int          T_RCD   = 3,
  parameter int          T_CL    = 5,
  parameter int          T_WR    = 3,
  parameter logic [12:0] MR0_VAL = 13'h0520
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [3:0]        mem_cmd,
  output logic [BA_W-1:0]   mem_ba,
  output logic [12:0]       mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int MAX_GAP = max_gap(T_INIT, T_RP, T_RFC, T_MRD, T_RCD, T_CL, T_WR);
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  seq_state_e         state_q, state_d, ret_q, ret_d;
  logic               first_done_q;
  logic               wr_q;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic               ld;
  logic [CNT_W-1:0]   ld_val;
  logic [CNT_W-1:0]   wait_cnt;
  logic               wait_done;

  // Named internal events
  wire accept   = req_valid && req_ready;
  wire in_wait  = (state_q == ST_WAIT);
  wire rd_grab  = in_wait && wait_done && (ret_q == ST_RD_DONE);

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    ld      = 1'b0;
    ld_val  = '0;
    case (state_q)
      ST_WAIT:      if (wait_done) state_d = ret_q;
      ST_INIT_PRE:  begin ld = 1'b1; ld_val = CNT_W'(T_RP);  ret_d = ST_INIT_REF1; state_d = ST_WAIT; end
      ST_INIT_REF1: begin ld = 1'b1; ld_val = CNT_W'(T_RFC); ret_d = ST_INIT_REF2; state_d = ST_WAIT; end
      ST_INIT_REF2: begin ld = 1'b1; ld_val = CNT_W'(T_RFC); ret_d = ST_INIT_MRS;  state_d = ST_WAIT; end
      ST_INIT_MRS:  begin ld = 1'b1; ld_val = CNT_W'(T_MRD); ret_d = ST_IDLE;      state_d = ST_WAIT; end
      ST_IDLE:      if (accept) state_d = first_done_q ? ST_PRE : ST_ACT;
      ST_PRE:       begin ld = 1'b1; ld_val = CNT_W'(T_RP);  ret_d = ST_REF;       state_d = ST_WAIT; end
      ST_REF:       begin ld = 1'b1; ld_val = CNT_W'(T_RFC); ret_d = ST_ACT;       state_d = ST_WAIT; end
      ST_ACT:       begin ld = 1'b1; ld_val = CNT_W'(T_RCD); ret_d = wr_q ? ST_WRITE : ST_READ; state_d = ST_WAIT; end
      ST_WRITE:     begin ld = 1'b1; ld_val = CNT_W'(T_WR);  ret_d = ST_IDLE;      state_d = ST_WAIT; end
      ST_READ:      begin ld = 1'b1; ld_val = CNT_W'(T_CL);  ret_d = ST_RD_DONE;   state_d = ST_WAIT; end
      ST_RD_DONE:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_WAIT;
      ret_q        <= ST_INIT_PRE;
      first_done_q <= 1'b0;
      wr_q         <= 1'b0;
      row_q        <= '0;
      col_q        <= '0;
      wdata_q      <= '0;
      rdata_q      <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      if (accept) begin
        first_done_q <= 1'b1;
        wr_q         <= req_write;
        row_q        <= req_row;
        col_q        <= req_col;
        wdata_q      <= req_wdata;
      end
      if (rd_grab) rdata_q <= mem_dq_in;
    end
  end

  seq_wait_ctr #(
    .CNT_W     (CNT_W),
    .RESET_VAL (T_INIT)
  ) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .cnt      (wait_cnt),
    .done     (wait_done)
  );

  seq_cmd_encode #(
    .ROW_W   (ROW_W),
    .COL_W   (COL_W),
    .MR0_VAL (MR0_VAL)
  ) u_enc (
    .state (state_q),
    .row   (row_q),
    .col   (col_q),
    .cmd   (mem_cmd),
    .addr  (mem_addr)
  );

  assign mem_ba     = '0;
  assign mem_dq_oe  = (state_q == ST_WRITE);
  assign mem_dq_out = wdata_q;
  assign rd_valid   = (state_q == ST_RD_DONE);
  assign rd_data    = rdata_q;

  // ---------------- assertions ----------------
  assert_ba_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ba == '0);

  assert_cmd_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd != CMD_NOP) |=> (mem_cmd == CMD_NOP));

  assert_wait_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (wait_cnt != '0));

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_rdvalid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> (!rd_valid && req_ready));

  assert_oe_only_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_cmd == CMD_WR && !mem_addr[AUTO_PRE_BIT]));

  assert_pre_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == CMD_PRE) |-> (mem_addr == 13'h0400));

endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb_top;

  localparam int ROW_W = 13, COL_W = 10, DATA_W = 16, BA_W = 3;
  localparam int T_INIT = 10, T_RP = 3, T_RFC = 6, T_MRD = 4;
  localparam int T_RCD = 3, T_CL = 5, T_WR = 3;
  localparam logic [12:0] MR0 = 13'h0520;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DATA_W-1:0] req_wdata = '0, mem_dq_in = '0;
  logic req_ready, rd_valid, mem_dq_oe;
  logic [DATA_W-1:0] rd_data, mem_dq_out;
  logic [3:0] mem_cmd;
  logic [BA_W-1:0] mem_ba;
  logic [12:0] mem_addr;

  always #4 clk = ~clk;

  sdram_cmd_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BA_W(BA_W),
    .T_INIT(T_INIT), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .T_RCD(T_RCD), .T_CL(T_CL), .T_WR(T_WR), .MR0_VAL(MR0)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_cmd(mem_cmd), .mem_ba(mem_ba), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, fails = 0;
  // expected trace
  logic [3:0]  q_cmd[$];
  logic [12:0] q_addr[$];
  bit          q_rdv[$];
  logic [15:0] q_rdat[$];
  string       q_tag[$];
  bit first_seen = 0;
  int scoreboard[int];
  // memory model
  int marr[int];
  bit row_open = 0;
  logic [12:0] open_row = '0;
  bit rd_pend = 0;
  int rd_cnt = 0;
  int rd_key = 0;

  task automatic fail(input string tag, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s: %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
  endtask

  task automatic push(input logic [3:0] c, input logic [12:0] a, input int nops, input string tag);
    q_cmd.push_back(c); q_addr.push_back(a); q_rdv.push_back(0); q_rdat.push_back('0); q_tag.push_back(tag);
    for (int i = 0; i < nops; i++) begin
      q_cmd.push_back(C_NOP); q_addr.push_back('0); q_rdv.push_back(0); q_rdat.push_back('0); q_tag.push_back(tag);
    end
  endtask

  task automatic tick();
    logic [3:0] ec; logic [12:0] ea; bit ev; logic [15:0] ed; string tg; bit er;
    @(negedge clk);
    ec = C_NOP; ea = '0; ev = 0; ed = '0; tg = rst_n ? "R4" : "R1"; er = rst_n;
    if (q_cmd.size() != 0) begin
      ec = q_cmd.pop_front(); ea = q_addr.pop_front(); ev = q_rdv.pop_front();
      ed = q_rdat.pop_front(); tg = q_tag.pop_front(); er = 0;
    end
    checks++;
    if (mem_cmd !== ec) fail(tg, "mem_cmd", mem_cmd, ec);
    else if (mem_addr !== ea) fail(tg, "mem_addr", mem_addr, ea);
    else if (req_ready !== er) fail(tg, "req_ready", req_ready, er);
    checks++;
    if (mem_ba !== '0) fail("R3", "mem_ba", mem_ba, 0);
    checks++;
    if (rd_valid !== ev) fail("R8", "rd_valid", rd_valid, ev);
    else if (ev && rd_data !== ed) fail("R10", "rd_data", rd_data, ed);
    // behavioural bank-0 memory
    mem_dq_in = '0;
    if (rd_pend) begin
      rd_cnt++;
      if (rd_cnt == T_CL) begin
        mem_dq_in = marr.exists(rd_key) ? 16'(marr[rd_key]) : 16'h0;
        rd_pend = 0;
      end
    end
    if (mem_cmd != C_WR && mem_dq_oe) fail("R7", "mem_dq_oe outside WRITE", 1, 0);
    case (mem_cmd)
      C_PRE: row_open = 0;
      C_ACT: begin
        checks++;
        if (row_open) fail("R6", "ACTIVATE with open row", 1, 0);
        row_open = 1; open_row = mem_addr;
      end
      C_WR: begin
        checks++;
        if (!row_open || !mem_dq_oe) fail("R7", "WRITE legality (open,oe)", {row_open, mem_dq_oe}, 3);
        marr[int'({open_row, mem_addr[9:0]})] = int'(mem_dq_out);
      end
      C_RD: begin
        checks++;
        if (!row_open) fail("R8", "READ without open row", 0, 1);
        rd_pend = 1; rd_cnt = 0; rd_key = int'({open_row, mem_addr[9:0]});
      end
      default: ;
    endcase
  endtask

  task automatic push_op(input bit w, input logic [12:0] row, input logic [9:0] col, input logic [15:0] d);
    int key;
    key = int'({row, col});
    if (first_seen) begin
      push(C_PRE, 13'h0400, T_RP, "R6");
      push(C_REF, '0, T_RFC, "R6");
    end
    push(C_ACT, row, T_RCD, first_seen ? "R6" : "R5");
    first_seen = 1;
    if (w) begin
      push(C_WR, 13'(col), T_WR, "R7");
      scoreboard[key] = int'(d);
    end else begin
      push(C_RD, 13'(col), T_CL, "R8");
      q_cmd.push_back(C_NOP); q_addr.push_back('0); q_rdv.push_back(1);
      q_rdat.push_back(scoreboard.exists(key) ? 16'(scoreboard[key]) : 16'h0);
      q_tag.push_back("R8");
    end
  endtask

  // request is held until the first idle cycle, then accepted once
  task automatic do_op(input bit w, input logic [12:0] row, input logic [9:0] col, input logic [15:0] d);
    req_valid = 1; req_write = w; req_row = row; req_col = col; req_wdata = d;
    while (!req_ready) tick();
    push_op(w, row, col, d);
    tick();
    req_valid = 0;
  endtask

  task automatic drain(input int extra);
    while (q_cmd.size() != 0) tick();
    for (int i = 0; i < extra; i++) tick();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) tick();          // R1 reset state
    rst_n = 1;
    for (int i = 0; i < T_INIT - 1; i++) push(C_NOP, '0, 0, "R1");
    push(C_PRE, 13'h0400, T_RP, "R2");
    push(C_REF, '0, T_RFC, "R2");
    push(C_REF, '0, T_RFC, "R2");
    push(C_MRS, MR0, T_MRD, "R2");
    drain(3);
    do_op(1, 13'd5, 10'd7, 16'hA5A5);           // R5 first access, no precharge
    drain(2);
    do_op(1, 13'd5, 10'd8, 16'h1234);           // R6 later access
    // R4 stray request while busy, dropped before idle
    req_valid = 1; req_write = 1; req_row = 13'd3; req_col = 10'd1; req_wdata = 16'hDEAD;
    tick(); tick();
    req_valid = 0;
    drain(4);
    do_op(0, 13'd5, 10'd7, 16'h0);              // R8 / R10
    do_op(1, 13'h1FFF, 10'h3FF, 16'hFFFF);      // held across busy: accepted at first idle
    do_op(0, 13'h1FFF, 10'h3FF, 16'h0);         // R10 corner address
    do_op(0, 13'd5, 10'd8, 16'h0);
    do_op(1, 13'd5, 10'd7, 16'h0F0F);           // overwrite
    do_op(0, 13'd5, 10'd7, 16'h0);
    drain(5);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
    summary();
  end

endmodule